// File: doc/BRIEF.md
# Receive Ring Header Writer

This block sits between a MAC receive byte stream and a byte-wide packet SRAM. It stores each incoming frame in a circular receive region. The frame bytes go in at their final place four bytes past the current write pointer. The stream's trailing 4-byte CRC is part of the frame and is stored with it. When the frame ends, the block writes a 4-byte header in front of the frame. The header holds a ready marker, a status byte taken from the status input at end of frame, and the byte count in little-endian order. The block then moves its write pointer past the packet.

The header is written only after the frame is complete. Marker byte 0x01 is the last byte written, and the slot that follows the packet is first set to 0x00. A host that reads from its read pointer sees byte 0 as 0x00 (no packet) or 0x01 (packet ready), and never sees a half-written frame. The host returns its consumed position on `rd_ptr`. A frame that does not fit in the free space is dropped. A software reset input moves the ring back to its origin.

Top module: `rx_ring_writer`

## Requirements
- R1: After hardware reset, the block writes 0x00 at address 0, and `wr_ptr` is 0.
- R2: Every byte of an accepted frame, including the 4 CRC bytes at its end, is written in arrival order to addresses `wr_ptr`+4, `wr_ptr`+5, and so on, modulo 2^AW.
- R3: For an accepted frame of N bytes, header byte `wr_ptr`+1 holds the `in_status` value sampled with the last byte. Bytes `wr_ptr`+2 and `wr_ptr`+3 hold N, low byte first.
- R4: After the payload, the block writes 0x00 at `wr_ptr`+4+N, then the status and length bytes, and writes 0x01 at `wr_ptr` last. The byte at `wr_ptr` is never written with any value other than 0x00 or 0x01.
- R5: `wr_ptr` moves only in the cycle after the 0x01 marker write. It moves by N+4 modulo 2^AW, so the ring wraps.
- R6: A frame is dropped when N+5 exceeds the free space (`rd_ptr` − `wr_ptr` − 1) mod 2^AW. A dropped frame pulses `drop`, leaves `wr_ptr` unchanged, and leaves 0x00 at `wr_ptr`.
- R7: `pkt_ready` is high exactly when `wr_ptr` differs from `rd_ptr`.
- R8: A high `soft_rst` discards any frame in progress and sets `wr_ptr` to 0. In the following cycle it writes 0x00 at address 0.
- R9: A start byte that arrives while a frame is being received discards the partial frame, pulses `drop`, and begins the new frame. A frame that starts while a header is being written is dropped entirely.
- R10: Bytes with `in_valid` low, and non-start bytes that arrive outside a frame, write nothing and leave `wr_ptr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| soft_rst | input | 1 | Synchronous software reset of the ring pointer |
| in_valid | input | 1 | Stream byte valid |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Stream byte |
| in_status | input | 8 | Receive status, sampled with the last byte |
| rd_ptr | input | AW | Host consumed position in the ring |
| mem_we | output | 1 | SRAM byte write enable |
| mem_addr | output | AW | SRAM byte address |
| mem_wdata | output | 8 | SRAM write byte |
| wr_ptr | output | AW | Start of the next packet slot |
| pkt_ready | output | 1 | At least one unread packet in the ring |
| drop | output | 1 | One-cycle pulse when a frame is discarded |

## Verification
The bench builds the block with AW=6, which gives a 64-byte ring. It sweeps every frame length from 1 to 58, the largest that fits in an empty ring. With this size the write pointer wraps many times during the sweep, and payloads and headers straddle the top of the ring. The small ring also makes the free-space limit easy to hit. Length 59 overflows an empty ring. A lagging host pointer produces both an exactly fitting frame and a rejected single-byte frame. The expected memory image is computed in the bench from the byte pattern and the length.

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int AW = 14,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic [7:0]    in_data,
  input  logic [7:0]    in_status,
  input  logic [AW-1:0] rd_ptr,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic [AW-1:0] wr_ptr,
  output logic          pkt_ready,
  output logic          drop
);
  localparam logic [AW-1:0] ONE  = AW'(1);
  localparam logic [AW-1:0] FOUR = AW'(4);

  typedef enum logic [1:0] {S_INIT, S_IDLE, S_RECV, S_HDR} st_t;

  st_t           st;
  logic [AW-1:0] cnt;
  logic [2:0]    step;
  logic [7:0]    stat;

  wire [AW-1:0] free     = rd_ptr - wr_ptr - ONE;
  wire          open_st  = (st == S_IDLE) || (st == S_RECV);
  wire          take_sof = in_valid && in_sof && open_st;
  wire          take_mid = in_valid && !in_sof && (st == S_RECV);
  wire [AW:0]   need     = (take_sof ? '0 : {1'b0, cnt}) + (AW+1)'(6);
  wire          fits     = need <= {1'b0, free};
  wire [LW-1:0] lenv     = LW'(cnt);
  wire [AW-1:0] pay_addr = wr_ptr + FOUR + (take_sof ? '0 : cnt);

  assign pkt_ready = wr_ptr != rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_INIT;
      wr_ptr    <= '0;
      cnt       <= '0;
      step      <= '0;
      stat      <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      drop      <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      drop   <= 1'b0;
      if (soft_rst) begin
        st     <= S_INIT;
        wr_ptr <= '0;
        cnt    <= '0;
        step   <= '0;
      end else begin
        case (st)
          S_INIT: begin
            mem_we    <= 1'b1;
            mem_addr  <= wr_ptr;
            mem_wdata <= 8'h00;
            st        <= S_IDLE;
          end
          S_IDLE, S_RECV: begin
            if (take_sof || take_mid) begin
              if (take_sof && st == S_RECV) drop <= 1'b1;
              if (!fits) begin
                drop <= 1'b1;
                st   <= S_IDLE;
              end else begin
                mem_we    <= 1'b1;
                mem_addr  <= pay_addr;
                mem_wdata <= in_data;
                cnt       <= take_sof ? ONE : cnt + ONE;
                if (in_eof) begin
                  st   <= S_HDR;
                  step <= '0;
                  stat <= in_status;
                end else begin
                  st <= S_RECV;
                end
              end
            end
          end
          S_HDR: begin
            if (in_valid && in_sof) drop <= 1'b1;
            step <= step + 3'd1;
            case (step)
              3'd0: begin
                mem_we    <= 1'b1;
                mem_addr  <= wr_ptr + FOUR + cnt;
                mem_wdata <= 8'h00;
              end
              3'd1: begin
                mem_we    <= 1'b1;
                mem_addr  <= wr_ptr + ONE;
                mem_wdata <= stat;
              end
              3'd2: begin
                mem_we    <= 1'b1;
                mem_addr  <= wr_ptr + AW'(2);
                mem_wdata <= lenv[7:0];
              end
              3'd3: begin
                mem_we    <= 1'b1;
                mem_addr  <= wr_ptr + AW'(3);
                mem_wdata <= lenv[15:8];
              end
              3'd4: begin
                mem_we    <= 1'b1;
                mem_addr  <= wr_ptr;
                mem_wdata <= 8'h01;
              end
              default: begin
                wr_ptr <= wr_ptr + FOUR + cnt;
                st     <= S_IDLE;
              end
            endcase
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module rx_ring_writer_chk #(
  parameter int AW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          soft_rst,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    mem_wdata,
  input logic [AW-1:0] wr_ptr
);
  logic [AW-1:0] prev_wr;
  logic          prev_soft;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_wr   <= '0;
      prev_soft <= 1'b0;
    end else begin
      prev_wr   <= wr_ptr;
      prev_soft <= soft_rst;
    end
  end
  wire [AW-1:0] adv = wr_ptr - prev_wr;

  // R4
  marker_before_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr != $past(wr_ptr) && !$past(soft_rst)) |->
      ($past(mem_we) && $past(mem_wdata) == 8'h01 && $past(mem_addr) == $past(wr_ptr)));

  // R4
  head_byte_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr == wr_ptr) |-> (mem_wdata == 8'h00 || mem_wdata == 8'h01));

  // R5
  advance_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv != '0 && !prev_soft) |-> (adv >= AW'(5)));

  // R8
  soft_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_rst) |-> (wr_ptr == '0));

  // R8
  soft_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(soft_rst, 2) && !$past(soft_rst)) |->
      (mem_we && mem_addr == '0 && mem_wdata == 8'h00));
endmodule

bind rx_ring_writer rx_ring_writer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .wr_ptr(wr_ptr));

// File: tb/test_rx_ring_writer.sv
`timescale 1ns/1ps
module test_rx_ring_writer;
  localparam int AW = 6;
  localparam int SZ = 64;

  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = '0, in_status = '0;
  logic [AW-1:0] rd_ptr = '0;
  logic mem_we, pkt_ready, drop;
  logic [AW-1:0] mem_addr, wr_ptr;
  logic [7:0] mem_wdata;

  rx_ring_writer #(.AW(AW), .LW(16)) i_rx_ring_writer (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .in_valid(in_valid),
    .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data), .in_status(in_status),
    .rd_ptr(rd_ptr), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .wr_ptr(wr_ptr), .pkt_ready(pkt_ready), .drop(drop));

  always #2 clk = ~clk;

  logic [7:0] mem [SZ];
  int checks = 0, fails = 0, wr_count = 0, exp_wr = 0;
  bit drop_seen = 0, done = 0;

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wr_count++;
    end
    if (drop) drop_seen = 1;
  end

  function automatic logic [7:0] pat(int seed, int i);
    return 8'((seed * 7 + i * 13 + 1) & 255);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(int len, int st, int seed, bit with_eof);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sof = (i == 0);
      in_eof = with_eof && (i == len - 1);
      in_data = pat(seed, i);
      in_status = 8'(st);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  task automatic verify_frame(int len, int st, int seed, string tag);
    int bad = 0;
    chk({tag, " R4 marker"}, mem[exp_wr], 1);
    chk({tag, " R3 status"}, mem[(exp_wr + 1) % SZ], st & 255);
    chk({tag, " R3 len lo"}, mem[(exp_wr + 2) % SZ], len & 255);
    chk({tag, " R3 len hi"}, mem[(exp_wr + 3) % SZ], len >> 8);
    for (int i = 0; i < len; i++)
      if (mem[(exp_wr + 4 + i) % SZ] != pat(seed, i)) bad++;
    chk({tag, " R2 payload mismatches"}, bad, 0);
    chk({tag, " R4 next slot empty"}, mem[(exp_wr + 4 + len) % SZ], 0);
    exp_wr = (exp_wr + 4 + len) % SZ;
    chk({tag, " R5 wr_ptr"}, wr_ptr, exp_wr);
    chk({tag, " R7 ready"}, pkt_ready, (exp_wr != rd_ptr) ? 1 : 0);
  endtask

  task automatic consume();
    rd_ptr = AW'(exp_wr);
    #1;
    chk("R7 ready after consume", pkt_ready, 0);
  endtask

  task automatic expect_drop(string tag);
    chk({tag, " R6 drop pulse"}, drop_seen, 1);
    chk({tag, " R6 wr_ptr held"}, wr_ptr, exp_wr);
    chk({tag, " R6 head stays empty"}, mem[exp_wr], 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int wc;
    for (int i = 0; i < SZ; i++) mem[i] = 8'hEE;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 wr_ptr", wr_ptr, 0);
    chk("R1 origin marker", mem[0], 0);
    chk("R7 ready at reset", pkt_ready, 0);

    // length sweep with ring wrap (R2 R3 R4 R5)
    for (int len = 1; len <= 58; len++) begin
      drive(len, len * 37, len, 1'b1);
      settle();
      verify_frame(len, len * 37, len, "sweep");
      consume();
    end

    // overflow of an empty ring (R6)
    drop_seen = 0;
    drive(59, 5, 99, 1'b1);
    settle();
    expect_drop("len59");

    // lagging host: exact fit then a rejected frame (R6)
    rd_ptr = AW'((exp_wr + 20) % SZ);
    drive(14, 8'h41, 3, 1'b1);
    settle();
    verify_frame(14, 8'h41, 3, "exact fit");
    drop_seen = 0;
    drive(1, 2, 4, 1'b1);
    settle();
    expect_drop("one byte no room");
    consume();

    // restart inside a frame (R9)
    drop_seen = 0;
    drive(5, 0, 11, 1'b0);
    drive(7, 8'h22, 12, 1'b1);
    settle();
    chk("R9 restart drop pulse", drop_seen, 1);
    verify_frame(7, 8'h22, 12, "R9 restart");
    consume();

    // frame starting during header write (R9)
    drop_seen = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == 3);
      in_data = pat(21, i); in_status = 8'h90;
    end
    drive(3, 8'h55, 22, 1'b1);
    settle();
    chk("R9 collision drop pulse", drop_seen, 1);
    verify_frame(4, 8'h90, 21, "R9 collision");
    consume();

    // ignored bytes (R10)
    wc = wr_count;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sof = i[0]; in_eof = i[1]; in_data = 8'hA5;
    end
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b0; in_eof = (i == 5); in_data = 8'h5A;
    end
    @(negedge clk);
    in_valid = 1'b0; in_eof = 1'b0;
    settle();
    chk("R10 no writes", wr_count, wc);
    chk("R10 wr_ptr held", wr_ptr, exp_wr);

    // software reset mid-frame (R8)
    mem[0] = 8'hEE;
    drive(5, 0, 31, 1'b0);
    @(negedge clk) soft_rst = 1'b1;
    @(negedge clk) soft_rst = 1'b0;
    settle();
    exp_wr = 0;
    chk("R8 wr_ptr origin", wr_ptr, 0);
    chk("R8 origin marker", mem[0], 0);
    rd_ptr = '0;
    #1;
    chk("R8 R7 ready cleared", pkt_ready, 0);
    drive(9, 8'h77, 33, 1'b1);
    settle();
    verify_frame(9, 8'h77, 33, "R8 after reset");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule